// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block sits between already-synchronized GPIO input bits and the logic that consumes them: the input data register and the interrupt detector. Every pin can have a glitch filter switched on or off on its own. All filtered pins share a single programmable minimum pulse width, counted in debounce ticks. A prescaler derives those ticks from the system clock. A filtered pin's output takes a new level only after the raw input has differed from it on a run of consecutive ticks. A pin with its filter switched off passes the raw level straight through, with no register stage in the path.

Software sets the filter through two 32-bit registers on a simple word bus: a pin-enable mask and a shared control word. The control word holds the pulse-width field, the prescaler divide value and a global run bit. Reads are combinational on the address. Writes take effect at the clock edge on which the write strobe is sampled. The control word resets to a three-count width field with the run bit set, so a pin that is enabled with no further setup rejects any pulse shorter than four ticks.

Top module: `gpio_debounce`

## Requirements
- R1: After reset the enable register reads 0 and the control register reads 0x8000_0003. From reset onward, each filtered output equals its raw input until an enabled filter holds a different level, so no false edge appears when reset is released.
- R2: The enable mask is at byte address 0x70, with bit i belonging to pin i. The control word is at 0x74: bits 7:0 hold the width field W, bits 23:16 hold the divide value D, and bit 31 is the run bit. All other bits of the control word read as 0. Every other address reads as 0.
- R3: When a pin's enable bit is 0, its filtered output equals its raw input in the same cycle.
- R4: When a pin is enabled and its raw input has differed from its output at W+1 consecutive tick edges, the output takes the raw level in the cycle after the last of those edges.
- R5: On an enabled pin, a raw pulse that returns to the output level before W+1 ticks have been counted leaves the output unchanged, and the tick count starts again from zero.
- R6: While the run bit is 1, a tick occurs on one clock cycle out of every D+1. D=0 gives a tick on every cycle.
- R7: While the run bit is 0, no ticks occur, and the outputs of enabled pins hold their level whatever the raw inputs do.
- R8: Clearing a pin's enable bit in the middle of a count discards that count. When the bit is set again, counting starts from zero.
- R9: Each pin filters independently. Activity on one pin never changes the output or the count of another pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on the address |
| pin_raw_i | input | NPIN | Synchronized raw pin levels |
| pin_filt_o | output | NPIN | Filtered pin levels |

## Verification
Two things can land in the same clock edge. A register write can change the width field, the divide value or an enable bit on the very edge where a tick lets a pin's count reach its limit. The raw input can also return to the output level on the same edge where a tick would have accepted it. A random phase writes to the control and enable registers at random times while the pin inputs toggle, so such collisions happen many times. A behavioural model in the bench uses the register values from before the edge and is compared with the outputs and read data on every cycle. Directed sequences pin down the exact acceptance cycle for known widths.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
package dbf_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned OFS_EN   = 'h70;
  localparam int unsigned OFS_CTRL = 'h74;
  localparam int unsigned THR_LSB  = 0;
  localparam int unsigned THR_W    = 8;
  localparam int unsigned DIV_LSB  = 16;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned RUN_BIT  = 31;
  localparam logic [REG_W-1:0] CTRL_RST  = 32'h8000_0003;
  localparam logic [REG_W-1:0] CTRL_MASK = 32'h80FF_00FF;
endpackage

// File: rtl/dbf_regs.sv
`timescale 1ns/1ps
module dbf_regs
  import dbf_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic [NPIN-1:0]     en_o,
  output logic [THR_W-1:0]    thr_o,
  output logic [DIV_W-1:0]    div_o,
  output logic                run_o
);
  // NPIN must not exceed REG_W
  logic [NPIN-1:0]  en_q;
  logic [REG_W-1:0] ctrl_q;
  logic             hit_en, hit_ctrl;

  assign hit_en   = (addr_i == ADDR_W'(OFS_EN));
  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      ctrl_q <= CTRL_RST;
    end else if (we_i) begin
      if (hit_en)   en_q   <= wdata_i[NPIN-1:0];
      if (hit_ctrl) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_en)        rdata_o[NPIN-1:0] = en_q;
    else if (hit_ctrl) rdata_o = ctrl_q & CTRL_MASK;
  end

  assign en_o  = en_q;
  assign thr_o = ctrl_q[THR_LSB +: THR_W];
  assign div_o = ctrl_q[DIV_LSB +: DIV_W];
  assign run_o = ctrl_q[RUN_BIT];

  p_en_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_en) |=> (en_q == $past(wdata_i[NPIN-1:0])))
    else $error("enable write not captured");
endmodule

// File: rtl/dbf_tick.sv
`timescale 1ns/1ps
module dbf_tick
  import dbf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] presc_q;

  // >= keeps the period bounded when div shrinks below the running count
  assign tick_o = run_i && (presc_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      presc_q <= '0;
    else if (!run_i)  presc_q <= '0;
    else if (tick_o)  presc_q <= '0;
    else              presc_q <= presc_q + 1'b1;
  end

  p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0))
    else $error("back-to-back ticks with nonzero divide");
endmodule

// File: rtl/dbf_pin.sv
`timescale 1ns/1ps
module dbf_pin
  import dbf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             raw_i,
  output logic             filt_o
);
  logic             filt_q;
  logic [THR_W-1:0] cnt_q;
  logic [THR_W:0]   cnt_nx;
  logic             hit;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign hit    = cnt_nx > {1'b0, thr_i};   // count+1 reached field+1

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!init_i || !en_i) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else if (raw_i == filt_q) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (hit) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx[THR_W-1:0];
      end
    end
  end

  assign filt_o = (init_i && en_i) ? filt_q : raw_i;

  p_change_needs_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(init_i) && $past(en_i) && filt_q != $past(filt_q)) |-> $past(tick_i))
    else $error("filtered level changed without a tick");

  p_match_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && en_i && raw_i == filt_q) |=> (cnt_q == '0))
    else $error("count kept while input matches output");

  p_disabled_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (cnt_q == '0))
    else $error("count survived disable");
endmodule

// File: rtl/gpio_debounce.sv
`timescale 1ns/1ps
module gpio_debounce
  import dbf_pkg::*;
#(
  parameter int unsigned NPIN   = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [NPIN-1:0]   pin_raw_i,
  output logic [NPIN-1:0]   pin_filt_o
);
  logic [NPIN-1:0]  en_q;
  logic [THR_W-1:0] thr;
  logic [DIV_W-1:0] div;
  logic             run, tick, init_q;

  // first cycle after reset loads every filter from its input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b0;
    else         init_q <= 1'b1;
  end

  dbf_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .en_o(en_q),
    .thr_o(thr), .div_o(div), .run_o(run)
  );

  dbf_tick u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(div), .tick_o(tick)
  );

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    dbf_pin u_pin (
      .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_q), .en_i(en_q[g]),
      .tick_i(tick), .thr_i(thr), .raw_i(pin_raw_i[g]), .filt_o(pin_filt_o[g])
    );
  end

  p_hold_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !run && !reg_we_i) |=> ((pin_filt_o & en_q) == $past(pin_filt_o & en_q)))
    else $error("enabled output moved while stopped");
endmodule

// File: tb/gpio_debounce_tb.sv
`timescale 1ns/1ps
module gpio_debounce_tb;
  localparam int NPIN = 8;
  localparam int ADDR_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic [NPIN-1:0]   pin_raw_i = 8'hA5;
  logic [NPIN-1:0]   pin_filt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R1";

  always #2 clk_i = ~clk_i;  // 250 MHz

  gpio_debounce #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_dut (.*);

  // behavioural reference model
  int m_init = 0;
  bit [NPIN-1:0] m_en = '0;
  int m_thr = 3, m_div = 0, m_run = 1, m_pc = 0;
  bit [NPIN-1:0] m_f = '0;
  int m_c [NPIN];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_init = 0; m_en = '0; m_thr = 3; m_div = 0; m_run = 1; m_pc = 0; m_f = '0;
      for (int i = 0; i < NPIN; i++) m_c[i] = 0;
    end else begin
      bit tk;
      tk = (m_run != 0) && (m_pc >= m_div);
      for (int i = 0; i < NPIN; i++) begin
        if (m_init == 0 || !m_en[i]) begin m_f[i] = pin_raw_i[i]; m_c[i] = 0; end
        else if (pin_raw_i[i] == m_f[i]) m_c[i] = 0;
        else if (tk) begin
          if (m_c[i] + 1 >= m_thr + 1) begin m_f[i] = pin_raw_i[i]; m_c[i] = 0; end
          else m_c[i] = m_c[i] + 1;
        end
      end
      if (m_run == 0 || tk) m_pc = 0; else m_pc = m_pc + 1;
      if (reg_we_i && reg_addr_i == 8'h70) m_en = reg_wdata_i[NPIN-1:0];
      if (reg_we_i && reg_addr_i == 8'h74) begin
        m_thr = int'(reg_wdata_i[7:0]); m_div = int'(reg_wdata_i[23:16]); m_run = int'(reg_wdata_i[31]);
      end
      m_init = 1;
    end
  end

  function automatic bit [NPIN-1:0] exp_out();
    bit [NPIN-1:0] e;
    for (int i = 0; i < NPIN; i++) e[i] = (m_init == 0 || !m_en[i]) ? pin_raw_i[i] : m_f[i];
    return e;
  endfunction

  function automatic bit [31:0] exp_rd();
    if (reg_addr_i == 8'h70) return {{(32-NPIN){1'b0}}, m_en};
    if (reg_addr_i == 8'h74) return {m_run[0], 7'b0, m_div[7:0], 8'b0, m_thr[7:0]};
    return 32'h0;
  endfunction

  // per-cycle comparison away from the active edge
  always @(negedge clk_i) begin
    checks++;
    if (pin_filt_o !== exp_out()) begin
      fails++;
      $display("FAIL %s: pin_filt_o=%h expected %h at %0t", cur_req, pin_filt_o, exp_out(), $time);
    end
    checks++;
    if (reg_rdata_o !== exp_rd()) begin
      fails++;
      $display("FAIL %s: reg_rdata_o=%h expected %h addr %h", cur_req, reg_rdata_o, exp_rd(), reg_addr_i);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step(1);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    bit [31:0] lfsr = 32'h1ACE_B00C;
    // R1: reset state, no false edge
    step(3);
    chk("R1", {24'b0, pin_filt_o}, 32'h0000_00A5);
    rst_ni = 1'b1;
    step(2);
    chk("R1", {24'b0, pin_filt_o}, 32'h0000_00A5);
    rd_chk("R1", 8'h74, 32'h8000_0003);
    rd_chk("R1", 8'h70, 32'h0);

    // R2: map, reserved bits, unmapped addresses
    cur_req = "R2";
    wr(8'h70, 32'hFFFF_FFFF);
    rd_chk("R2", 8'h70, 32'h0000_00FF);
    wr(8'h74, 32'hFFFF_FFFF);
    rd_chk("R2", 8'h74, 32'h80FF_00FF);
    rd_chk("R2", 8'h00, 32'h0);
    rd_chk("R2", 8'h78, 32'h0);
    wr(8'h74, 32'h8000_0003);
    wr(8'h70, 32'h0);

    // R3: pass-through when disabled
    cur_req = "R3";
    for (int k = 0; k < 20; k++) begin
      pin_raw_i = pin_raw_i ^ 8'(k * 37 + 5);
      #1;
      chk("R3", {24'b0, pin_filt_o}, {24'b0, pin_raw_i});
      step(1);
    end

    // R4: acceptance after W+1 ticks (W=3, D=0)
    cur_req = "R4";
    pin_raw_i = 8'h01;
    wr(8'h70, 32'h01);
    pin_raw_i = 8'h00;
    step(3);
    chk("R4", {31'b0, pin_filt_o[0]}, 32'h1);
    step(1);
    chk("R4", {31'b0, pin_filt_o[0]}, 32'h0);

    // R5: short pulse rejected, count restarts
    cur_req = "R5";
    pin_raw_i = 8'h01; step(3);
    pin_raw_i = 8'h00; step(5);
    chk("R5", {31'b0, pin_filt_o[0]}, 32'h0);
    pin_raw_i = 8'h01; step(3);
    chk("R5", {31'b0, pin_filt_o[0]}, 32'h0);
    step(1);
    chk("R4", {31'b0, pin_filt_o[0]}, 32'h1);

    // R7: stopped ticks hold enabled outputs
    cur_req = "R7";
    wr(8'h74, 32'h0000_0003);
    pin_raw_i = 8'h00; step(20);
    chk("R7", {31'b0, pin_filt_o[0]}, 32'h1);
    wr(8'h74, 32'h8000_0003);
    step(6);
    chk("R7", {31'b0, pin_filt_o[0]}, 32'h0);

    // R8: disable mid-count discards it
    cur_req = "R8";
    pin_raw_i = 8'h01; step(2);
    wr(8'h70, 32'h0);
    chk("R8", {31'b0, pin_filt_o[0]}, 32'h1);
    wr(8'h70, 32'h01);
    pin_raw_i = 8'h00; step(3);
    chk("R8", {31'b0, pin_filt_o[0]}, 32'h1);
    step(1);
    chk("R8", {31'b0, pin_filt_o[0]}, 32'h0);

    // R9: independent pins, W=1
    cur_req = "R9";
    wr(8'h74, 32'h8000_0001);
    wr(8'h70, 32'hFF);
    step(2);
    pin_raw_i = 8'h02; step(1);
    pin_raw_i = 8'h06; step(1);
    chk("R9", {24'b0, pin_filt_o}, 32'h02);
    step(1);
    chk("R9", {24'b0, pin_filt_o}, 32'h06);

    // R6: D=3, W=0 -> accepted within four cycles
    cur_req = "R6";
    wr(8'h74, 32'h8003_0000);
    pin_raw_i = 8'h0E; step(5);
    chk("R6", {24'b0, pin_filt_o}, 32'h0E);

    // random collisions of writes, ticks and input activity
    cur_req = "R4";
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      reg_we_i = (lfsr[3:0] == 4'h0);
      reg_addr_i = lfsr[4] ? 8'h70 : (lfsr[5] ? 8'h74 : 8'h00);
      reg_wdata_i = {lfsr[6] | lfsr[7], 7'b0, 6'b0, lfsr[9:8], 5'b0, lfsr[12:10], lfsr[27:20]};
      if (lfsr[15:13] == 3'b000) pin_raw_i = pin_raw_i ^ (8'h01 << lfsr[18:16]);
      step(1);
    end
    reg_we_i = 1'b0;
    step(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule